// File: doc/BRIEF.md
# Cumulative Row Boundary Address Decoder

This block decides which of a set of memory rows a physical address falls in. Software programs one small boundary value per row. Each value is the running top of memory at the end of that row, counted in 8 MB steps. A row therefore begins where the row below it ends. Row 0 begins at address zero.

A row whose boundary equals the boundary below it holds no memory and is skipped. A boundary of zero that follows a nonzero boundary stands for the full 2 GB top of the space. This lets the last populated row reach 2 GB, which the 8-bit field alone cannot express.

The address is decoded combinationally against the programmed rows. The block registers the matching row number, a hit flag and the row's start and exclusive end address, and presents them one cycle later. An address outside every row gives a miss.

Top module: `row_bound_decoder`

## Requirements
- R1: Eight boundary registers, each 8 bits, are written through `wr_en`/`wr_row`/`wr_val` on a rising clock edge. A write takes effect for addresses presented from the next cycle on. Reset clears all of them, so every address misses.
- R2: A row's exclusive end address is its boundary value shifted left by 23 bits, which is a multiple of 8 MB.
- R3: Row n covers addresses from the end of row n-1 (zero for row 0) up to, but not including, its own end. `base_o` and `limit_o` report these two addresses for the selected row.
- R4: A row whose end equals the end of the row below it is empty and is never selected.
- R5: A boundary value of zero whose predecessor end is nonzero gives an end of 0x8000_0000 (2 GB). A zero in row 0, or a zero after a zero end, gives an end of zero.
- R6: An address that lies in no row gives `hit_o`=0 with `row_o`, `base_o` and `limit_o` all zero. This includes any address at or above the highest end.
- R7: When the ranges of several rows contain the address (non-increasing programming), the lowest-numbered such row is selected.
- R8: Outputs are registered. They reflect the address and boundaries present at the previous rising edge, and they are zero while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Boundary register write strobe |
| wr_row | input | 3 | Row whose boundary is written |
| wr_val | input | 8 | Boundary value in 8 MB units |
| addr_i | input | 32 | Physical address to decode |
| hit_o | output | 1 | Address lies in a populated row |
| row_o | output | 3 | Selected row number (0 on miss) |
| base_o | output | 32 | Start address of selected row (0 on miss) |
| limit_o | output | 32 | Exclusive end address of selected row (0 on miss) |

## Verification
The assertions check several properties on every cycle. A reported hit always lies inside the reported range, taken against the address of the previous cycle. A selected row is never empty and its end falls on an 8 MB step. A miss always reports zeros, and the outputs are quiet just after reset.

Only the bench's scenarios can show the rest. These are that the right row is chosen among overlapping ranges, that the 2 GB encoding of a zero boundary works, that empty rows are skipped, and that writes land in the intended register. The bench sweeps the address space in 4 MB steps and probes every row edge, under several boundary programmings.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
   // default geometry of the decoder
   localparam int RBD_ROWS_DEF   = 8;
   localparam int RBD_BND_W_DEF  = 8;
   localparam int RBD_SHIFT_DEF  = 23;
   localparam int RBD_ADDR_W_DEF = 32;

   // width of a row index for a given row count
   function automatic int rbd_idx_w(input int rows);
      return (rows > 1) ? $clog2(rows) : 1;
   endfunction
endpackage

// File: rtl/rbd_bound_regs.sv
module rbd_bound_regs #(
   parameter int NUM_ROWS = 8,
   parameter int BND_W    = 8,
   parameter int IDX_W    = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [IDX_W-1:0]                   wr_row,
   input  logic [BND_W-1:0]                   wr_val,
   output logic [NUM_ROWS-1:0][BND_W-1:0]     bnd_o
);
   if (NUM_ROWS > (1 << IDX_W)) begin : g_bad_idx
      $error("rbd_bound_regs: IDX_W too narrow for NUM_ROWS");
   end

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      logic sel;
      assign sel = wr_en && (wr_row == IDX_W'(r));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   bnd_o[r] <= '0;
         else if (sel) bnd_o[r] <= wr_val;
      end
   end
endmodule

// File: rtl/rbd_limit_chain.sv
module rbd_limit_chain #(
   parameter int NUM_ROWS   = 8,
   parameter int BND_W      = 8,
   parameter int UNIT_SHIFT = 23,
   parameter int ADDR_W     = 32
) (
   input  logic [NUM_ROWS-1:0][BND_W-1:0]  bnd_i,
   output logic [NUM_ROWS-1:0][ADDR_W-1:0] base_o,
   output logic [NUM_ROWS-1:0][ADDR_W-1:0] lim_o
);
   localparam int SPAN_W = BND_W + UNIT_SHIFT;
   localparam logic [ADDR_W-1:0] TOP_LIM = ADDR_W'(1) << SPAN_W;

   if (ADDR_W < SPAN_W + 1) begin : g_bad_w
      $error("rbd_limit_chain: ADDR_W cannot hold the top-of-space limit");
   end

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      logic [ADDR_W-1:0] prev;
      logic [ADDR_W-1:0] raw;
      if (r == 0) begin : g_first
         assign prev = '0;
      end else begin : g_next
         assign prev = lim_o[r-1];
      end
      assign raw       = ADDR_W'(bnd_i[r]) << UNIT_SHIFT;
      assign lim_o[r]  = ((prev != '0) && (bnd_i[r] == '0)) ? TOP_LIM : raw;
      assign base_o[r] = prev;
   end
endmodule

// File: rtl/rbd_row_match.sv
module rbd_row_match #(
   parameter int NUM_ROWS = 8,
   parameter int ADDR_W   = 32,
   parameter int IDX_W    = 3
) (
   input  logic [ADDR_W-1:0]               addr_i,
   input  logic [NUM_ROWS-1:0][ADDR_W-1:0] base_i,
   input  logic [NUM_ROWS-1:0][ADDR_W-1:0] lim_i,
   output logic                            hit_o,
   output logic [IDX_W-1:0]                idx_o
);
   logic [NUM_ROWS-1:0] in_rng;

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_cmp
      // an empty or inverted range never matches
      assign in_rng[r] = (addr_i >= base_i[r]) && (addr_i < lim_i[r]);
   end

   // lowest-numbered matching row wins
   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int r = NUM_ROWS - 1; r >= 0; r--) begin
         if (in_rng[r]) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(r);
         end
      end
   end
endmodule

// File: rtl/row_bound_decoder.sv
module row_bound_decoder
   import rbd_pkg::*;
#(
   parameter int NUM_ROWS   = RBD_ROWS_DEF,
   parameter int BND_W      = RBD_BND_W_DEF,
   parameter int UNIT_SHIFT = RBD_SHIFT_DEF,
   parameter int ADDR_W     = RBD_ADDR_W_DEF,
   localparam int IDX_W     = rbd_idx_w(NUM_ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_row,
   input  logic [BND_W-1:0]  wr_val,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [IDX_W-1:0]  row_o,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] limit_o
);
   if (NUM_ROWS < 1) begin : g_bad_rows
      $error("row_bound_decoder: NUM_ROWS must be at least 1");
   end
   if (UNIT_SHIFT < 1) begin : g_bad_shift
      $error("row_bound_decoder: UNIT_SHIFT must be at least 1");
   end

   logic [NUM_ROWS-1:0][BND_W-1:0]  bnd;
   logic [NUM_ROWS-1:0][ADDR_W-1:0] row_base;
   logic [NUM_ROWS-1:0][ADDR_W-1:0] row_lim;
   logic                            dec_hit;
   logic [IDX_W-1:0]                dec_idx;
   logic [ADDR_W-1:0]               sel_base;
   logic [ADDR_W-1:0]               sel_lim;

   rbd_bound_regs #(
      .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .IDX_W(IDX_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_row(wr_row), .wr_val(wr_val), .bnd_o(bnd)
   );

   rbd_limit_chain #(
      .NUM_ROWS(NUM_ROWS), .BND_W(BND_W),
      .UNIT_SHIFT(UNIT_SHIFT), .ADDR_W(ADDR_W)
   ) u_chain (
      .bnd_i(bnd), .base_o(row_base), .lim_o(row_lim)
   );

   rbd_row_match #(
      .NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
   ) u_match (
      .addr_i(addr_i), .base_i(row_base), .lim_i(row_lim),
      .hit_o(dec_hit), .idx_o(dec_idx)
   );

   // pick the matching row's range; zeros on a miss
   always_comb begin
      sel_base = '0;
      sel_lim  = '0;
      for (int r = 0; r < NUM_ROWS; r++) begin
         if (dec_hit && (dec_idx == IDX_W'(r))) begin
            sel_base = row_base[r];
            sel_lim  = row_lim[r];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_o   <= 1'b0;
         row_o   <= '0;
         base_o  <= '0;
         limit_o <= '0;
      end else begin
         hit_o   <= dec_hit;
         row_o   <= dec_idx;
         base_o  <= sel_base;
         limit_o <= sel_lim;
      end
   end
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
   parameter int NUM_ROWS   = 8,
   parameter int UNIT_SHIFT = 23,
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_i,
   input logic              hit_o,
   input logic [IDX_W-1:0]  row_o,
   input logic [ADDR_W-1:0] base_o,
   input logic [ADDR_W-1:0] limit_o
);
   logic [UNIT_SHIFT-1:0] low_bits;
   assign low_bits = limit_o[UNIT_SHIFT-1:0];

   AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (($past(addr_i) >= base_o) && ($past(addr_i) < limit_o))); // R3

   AST_NO_EMPTY_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (base_o < limit_o)); // R4

   AST_LIMIT_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (low_bits == '0)); // R2

   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_o |-> ((row_o == '0) && (base_o == '0) && (limit_o == '0))); // R6

   AST_ROW_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (32'(row_o) < NUM_ROWS)); // R7

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> !hit_o); // R8
endmodule

bind row_bound_decoder rbd_checker #(
   .NUM_ROWS(NUM_ROWS), .UNIT_SHIFT(UNIT_SHIFT),
   .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_rbd_chk (
   .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .hit_o(hit_o),
   .row_o(row_o), .base_o(base_o), .limit_o(limit_o)
);

// File: tb/row_bound_decoder_tb.sv
module row_bound_decoder_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_row = '0;
   logic [7:0]  wr_val = '0;
   logic [31:0] addr_i = '0;
   logic        hit_o;
   logic [2:0]  row_o;
   logic [31:0] base_o;
   logic [31:0] limit_o;

   int checks = 0;
   int fails  = 0;
   logic [7:0] cfg [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   row_bound_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
      .wr_val(wr_val), .addr_i(addr_i), .hit_o(hit_o), .row_o(row_o),
      .base_o(base_o), .limit_o(limit_o)
   );

   // end of row r per the requirements (R2, R5), as a 64-bit number
   function automatic longint row_end(input int r);
      longint prev = 0;
      longint lim  = 0;
      for (int i = 0; i <= r; i++) begin
         if (prev != 0 && cfg[i] == 0) lim = 64'h8000_0000;
         else                          lim = longint'(cfg[i]) << 23;
         if (i < r) prev = lim;
      end
      return lim;
   endfunction

   function automatic longint row_start(input int r);
      return (r == 0) ? 0 : row_end(r - 1);
   endfunction

   task automatic report(input string tag, input string what,
                         input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic program_cfg();
      for (int r = 0; r < 8; r++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_row = 3'(r); wr_val = cfg[r];
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // apply one address, check outputs one edge later (R8)
   task automatic probe(input string tag, input longint a);
      bit     e_hit = 0;
      int     e_row = 0;
      longint e_base = 0, e_lim = 0;
      if (a > 64'hFFFF_FFFF) return;
      for (int r = 7; r >= 0; r--) begin
         if (a >= row_start(r) && a < row_end(r)) begin
            e_hit = 1; e_row = r; e_base = row_start(r); e_lim = row_end(r);
         end
      end
      @(negedge clk);
      addr_i = 32'(a);
      @(negedge clk);
      checks++;
      if (hit_o != e_hit || int'(row_o) != e_row ||
          longint'(base_o) != e_base || longint'(limit_o) != e_lim) begin
         fails++;
         $display("FAIL %s addr=%0h actual hit=%0d row=%0d base=%0h lim=%0h expected hit=%0d row=%0d base=%0h lim=%0h",
                  tag, a, hit_o, row_o, base_o, limit_o,
                  e_hit, e_row, e_base, e_lim);
      end
   endtask

   task automatic sweep(input string tag);
      for (int k = 0; k <= 520; k++) probe(tag, longint'(k) << 22);
      for (int r = 0; r < 8; r++) begin
         probe(tag, row_start(r));
         if (row_end(r) > 0) probe(tag, row_end(r) - 1);
         probe(tag, row_end(r));
      end
      probe(tag, 64'hFFFF_FFFF);
   endtask

   task automatic load(input logic [7:0] v0, v1, v2, v3, v4, v5, v6, v7);
      cfg[0] = v0; cfg[1] = v1; cfg[2] = v2; cfg[3] = v3;
      cfg[4] = v4; cfg[5] = v5; cfg[6] = v6; cfg[7] = v7;
      program_cfg();
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      for (int r = 0; r < 8; r++) cfg[r] = '0;
      repeat (3) @(negedge clk);
      // R8: outputs zero in reset
      report("R8", "hit in reset", longint'(hit_o), 0);
      report("R8", "limit in reset", longint'(limit_o), 0);
      rst_n = 1'b1;
      // R1: after reset all rows empty, every address misses
      sweep("R1");
      // R4 / R6: empty rows 1 and 4, top at 1 GB
      load(8'd4, 8'd4, 8'd10, 8'd16, 8'd16, 8'd40, 8'd64, 8'd128);
      sweep("R4");
      probe("R6", 64'h4000_0000);
      // R5: zero after nonzero reaches 2 GB, later zeros empty
      load(8'd16, 8'd32, 8'd64, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0);
      sweep("R5");
      probe("R5", 64'h7FFF_FFFF);
      probe("R6", 64'h8000_0000);
      // R7: overlapping ranges, lowest row wins
      load(8'd4, 8'd2, 8'd8, 8'd8, 8'd8, 8'd8, 8'd8, 8'd8);
      sweep("R7");
      probe("R7", 64'h0140_0000);
      // R2 / R5: top byte value then zero for the last 8 MB
      load(8'd255, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0);
      sweep("R2");
      // R5: leading zero stays empty
      load(8'd0, 8'd5, 8'd5, 8'd9, 8'd9, 8'd9, 8'd200, 8'd201);
      sweep("R3");
      // R1: single rewrite takes effect next cycle
      cfg[6] = 8'd100;
      @(negedge clk);
      wr_en = 1'b1; wr_row = 3'd6; wr_val = 8'd100;
      @(negedge clk);
      wr_en = 1'b0;
      probe("R1", 64'h3200_0000);
      probe("R1", 64'h6000_0000);
      // R8: reset clears outputs mid-run
      probe("R8", 64'h0000_0000);
      rst_n = 1'b0;
      #1;
      report("R8", "hit after reset", longint'(hit_o), 0);
      report("R8", "base after reset", longint'(base_o), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule